// File: doc/BRIEF.md
# Descriptor-Driven Multi-Channel DMA Engine

This block moves data on behalf of up to eight channels through one simple memory port. Each channel owns two control descriptors, a primary and an alternate, kept in memory at a fixed base. A descriptor holds three words: where the source data ends, where the destination data ends, and a packed control word. The control word carries the cycle type, the number of transfers still to do, the data size, the address steps and how many transfers the channel may make before the engine arbitrates again.

When idle, the engine grants the highest-priority channel that has a pending request. It reads that channel's descriptor and performs read-then-write transfers. After a burst of 2^R transfers, or when the count runs out, it writes the control word back. A finished cycle is marked invalid in memory, raises a one-cycle done flag and, except in ping-pong, switches the channel off. Ping-pong flips the channel to its other descriptor and keeps it enabled.

Top module: `chan_dma_engine`

## Requirements
- R1: While reset is asserted, and after its release with no channel enabled, `mem_re_o`, `mem_we_o` and `done_o` stay low.
- R2: Control word bits [2:0] select the cycle: 001 basic, 010 auto-request, 011 ping-pong. Reading 000 or any of 100-111 switches the channel off with no data transfer and no done pulse.
- R3: Bits [13:4] hold k, the transfers left minus one. The transfer made while k has a given value uses address end pointer minus k times the step. Step codes are 00 = 1 byte, 01 = 2, 10 = 4 and 11 = no step, with the source step at [27:26] and the destination step at [31:30]. Data therefore lands in ascending order.
- R4: Size codes (source [25:24], destination [29:28]) are 00 byte, 01 halfword and 10 word. Each transfer moves exactly that many bytes.
- R5: With R in bits [17:14], a grant covers at most 2^R transfers (all remaining ones when R is 10 or more). It ends by writing the control word back with bits [13:4] equal to the count left minus one.
- R6: Among pending channels, those with `hipri_i` set win. Within a group, the lowest channel number wins.
- R7: A basic cycle runs one grant per sampled request. Without `req_i` it makes no further transfers.
- R8: An auto-request cycle continues grant after grant without further `req_i` until its count is done.
- R9: When a ping-pong cycle completes, the channel stays enabled and its next grant uses the other descriptor. It stops once it reads an invalid descriptor.
- R10: A completed cycle writes its control word back with bits [2:0] and [13:4] zero and pulses that channel's `done_o` bit for one cycle. A finished basic or auto channel then ignores `req_i`.
- R11: A pulse on `ch_en_i[c]` enables channel c and points it at its primary descriptor.
- R12: The descriptor of channel c sits at byte address DESC_BASE + (alt*NCH + c)*16, with alt = 0 for primary and 1 for alternate. It holds the source end at +0, the destination end at +4 and the control word at +8.
- R13: `mem_rdata_i` is taken in the same cycle as the read. Reads and writes never share a cycle, and descriptor accesses are word-sized.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NCH | Per-channel transfer request |
| ch_en_i | input | NCH | Per-channel enable pulse |
| hipri_i | input | NCH | Per-channel high-priority select |
| done_o | output | NCH | One-cycle cycle-complete pulse per channel |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | AW | Byte address |
| mem_size_o | output | 2 | Access size: 00 byte, 01 halfword, 10 word |
| mem_wdata_o | output | DW | Write data, low bytes significant |
| mem_rdata_i | input | DW | Read data, valid in the cycle of the read |

## Verification
The alignment and descriptor-size properties assume that software places source and destination end pointers on boundaries of their data size. They also assume that no data window overlaps the descriptor region. Every scenario in the bench sets up its descriptors within those limits. The port properties also assume that the memory answers a read in the same cycle. The bench model returns bytes combinationally from the address and size it sees.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;

   localparam logic [2:0] CC_STOP     = 3'b000;
   localparam logic [2:0] CC_BASIC    = 3'b001;
   localparam logic [2:0] CC_AUTO     = 3'b010;
   localparam logic [2:0] CC_PINGPONG = 3'b011;

   localparam int CNT_W   = 10;
   localparam int BURST_W = CNT_W + 1;

   typedef struct packed {
      logic [1:0]       dst_inc;
      logic [1:0]       dst_size;
      logic [1:0]       src_inc;
      logic [1:0]       src_size;
      logic [5:0]       spare;
      logic [3:0]       rpow;
      logic [CNT_W-1:0] nm1;
      logic             nxt_burst;
      logic [2:0]       cc;
   } ctrl_t;

   typedef enum logic [2:0] {
      ST_IDLE, ST_DSRC, ST_DDST, ST_DCTL, ST_XRD, ST_XWR, ST_WB
   } eng_st_t;

   function automatic logic [BURST_W-1:0] burst_len(input logic [3:0] r);
      if (r >= 4'd10) return BURST_W'(1024);
      return BURST_W'(1) << r;
   endfunction

   function automatic logic cc_runs(input logic [2:0] cc);
      return (cc == CC_BASIC) || (cc == CC_AUTO) || (cc == CC_PINGPONG);
   endfunction

endpackage

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
   parameter int NCH = 8,
   localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic [NCH-1:0] pend_i,
   input  logic [NCH-1:0] hipri_i,
   output logic           gnt_vld_o,
   output logic [CHW-1:0] gnt_idx_o
);

   logic [NCH-1:0] hi_set;
   logic [NCH-1:0] pool;

   assign hi_set    = pend_i & hipri_i;
   assign pool      = (|hi_set) ? hi_set : pend_i;
   assign gnt_vld_o = |pend_i;

   generate
      if (NCH == 1) begin : g_single
         assign gnt_idx_o = '0;
      end else begin : g_multi
         always_comb begin
            gnt_idx_o = '0;
            for (int i = NCH - 1; i >= 0; i--) begin
               if (pool[i]) gnt_idx_o = CHW'(i);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
   parameter int AW   = 32,
   parameter int CNTW = 10
) (
   input  logic [AW-1:0]   end_ptr_i,
   input  logic [CNTW-1:0] left_i,
   input  logic [1:0]      inc_i,
   output logic [AW-1:0]   addr_o
);

   logic [AW-1:0] left_ext;
   assign left_ext = AW'(left_i);

   always_comb begin
      unique case (inc_i)
         2'b00:   addr_o = end_ptr_i - left_ext;
         2'b01:   addr_o = end_ptr_i - (left_ext << 1);
         2'b10:   addr_o = end_ptr_i - (left_ext << 2);
         default: addr_o = end_ptr_i;
      endcase
   end

endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
   import dma_desc_pkg::*;
#(
   parameter int NCH = 8,
   localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] en_set_i,
   input  logic [NCH-1:0] req_i,
   input  logic           slot_end_i,
   input  logic           slot_fin_i,
   input  logic           kill_i,
   input  logic [CHW-1:0] cur_ch_i,
   input  logic [2:0]     cur_cc_i,
   output logic [NCH-1:0] pend_o,
   output logic [NCH-1:0] alt_o,
   output logic [NCH-1:0] done_o
);

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         logic en_q, alt_q, self_q, done_q;
         logic mine;

         assign mine = (cur_ch_i == CHW'(c));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               en_q   <= 1'b0;
               alt_q  <= 1'b0;
               self_q <= 1'b0;
               done_q <= 1'b0;
            end else begin
               done_q <= 1'b0;
               if (en_set_i[c]) begin
                  en_q   <= 1'b1;
                  alt_q  <= 1'b0;
                  self_q <= 1'b0;
               end else if (mine && kill_i) begin
                  en_q   <= 1'b0;
                  self_q <= 1'b0;
               end else if (mine && slot_end_i) begin
                  if (slot_fin_i) begin
                     done_q <= 1'b1;
                     self_q <= 1'b0;
                     if (cur_cc_i == CC_PINGPONG) alt_q <= ~alt_q;
                     else                         en_q  <= 1'b0;
                  end else if (cur_cc_i == CC_AUTO) begin
                     self_q <= 1'b1;
                  end
               end
            end
         end

         assign pend_o[c] = en_q & (req_i[c] | self_q);
         assign alt_o[c]  = alt_q;
         assign done_o[c] = done_q;
      end
   endgenerate

endmodule

// File: rtl/chan_dma_engine.sv
module chan_dma_engine
   import dma_desc_pkg::*;
#(
   parameter int          NCH       = 8,
   parameter int          AW        = 32,
   parameter int          DW        = 32,
   parameter int unsigned DESC_BASE = 32'h200
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] req_i,
   input  logic [NCH-1:0] ch_en_i,
   input  logic [NCH-1:0] hipri_i,
   output logic [NCH-1:0] done_o,
   output logic           mem_re_o,
   output logic           mem_we_o,
   output logic [AW-1:0]  mem_addr_o,
   output logic [1:0]     mem_size_o,
   output logic [DW-1:0]  mem_wdata_o,
   input  logic [DW-1:0]  mem_rdata_i
);

   localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

   generate
      if (NCH < 1 || NCH > 32) begin : g_bad_nch
         $error("NCH must lie in 1..32");
      end
      if (DW < 32) begin : g_bad_dw
         $error("DW must be at least 32");
      end
      if (AW < 12 || AW > DW) begin : g_bad_aw
         $error("AW must lie in 12..DW");
      end
   endgenerate

   eng_st_t           st;
   logic [CHW-1:0]    cur_ch;
   logic              cur_alt;
   logic [AW-1:0]     src_end, dst_end;
   ctrl_t             ctl;
   logic [CNT_W-1:0]  left;
   logic [BURST_W-1:0] bcnt;
   logic              fin;
   logic [DW-1:0]     data_q;

   logic              gnt_vld;
   logic [CHW-1:0]    gnt_idx;
   logic [NCH-1:0]    pend, alt_v;
   ctrl_t             rd_ctl, wb_ctl;
   logic              kill;
   logic [AW-1:0]     dbase, src_addr, dst_addr;

   assign rd_ctl = ctrl_t'(mem_rdata_i[31:0]);
   assign kill   = (st == ST_DCTL) && !cc_runs(rd_ctl.cc);
   assign dbase  = AW'(DESC_BASE)
                 + ((AW'(cur_alt) * AW'(NCH) + AW'(cur_ch)) << 4);

   dma_prio_arb #(.NCH(NCH)) u_arb (
      .pend_i    (pend),
      .hipri_i   (hipri_i),
      .gnt_vld_o (gnt_vld),
      .gnt_idx_o (gnt_idx)
   );

   dma_chan_ctl #(.NCH(NCH)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_set_i   (ch_en_i),
      .req_i      (req_i),
      .slot_end_i (st == ST_WB),
      .slot_fin_i (fin),
      .kill_i     (kill),
      .cur_ch_i   (cur_ch),
      .cur_cc_i   (ctl.cc),
      .pend_o     (pend),
      .alt_o      (alt_v),
      .done_o     (done_o)
   );

   dma_addr_step #(.AW(AW), .CNTW(CNT_W)) u_src_step (
      .end_ptr_i (src_end),
      .left_i    (left),
      .inc_i     (ctl.src_inc),
      .addr_o    (src_addr)
   );

   dma_addr_step #(.AW(AW), .CNTW(CNT_W)) u_dst_step (
      .end_ptr_i (dst_end),
      .left_i    (left),
      .inc_i     (ctl.dst_inc),
      .addr_o    (dst_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cur_ch  <= '0;
         cur_alt <= 1'b0;
         src_end <= '0;
         dst_end <= '0;
         ctl     <= '0;
         left    <= '0;
         bcnt    <= '0;
         fin     <= 1'b0;
         data_q  <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (gnt_vld) begin
                  cur_ch  <= gnt_idx;
                  cur_alt <= alt_v[gnt_idx];
                  st      <= ST_DSRC;
               end
            end
            ST_DSRC: begin
               src_end <= mem_rdata_i[AW-1:0];
               st      <= ST_DDST;
            end
            ST_DDST: begin
               dst_end <= mem_rdata_i[AW-1:0];
               st      <= ST_DCTL;
            end
            ST_DCTL: begin
               ctl  <= rd_ctl;
               left <= rd_ctl.nm1;
               bcnt <= burst_len(rd_ctl.rpow);
               fin  <= 1'b0;
               st   <= cc_runs(rd_ctl.cc) ? ST_XRD : ST_IDLE;
            end
            ST_XRD: begin
               data_q <= mem_rdata_i;
               st     <= ST_XWR;
            end
            ST_XWR: begin
               if (left == '0) begin
                  fin <= 1'b1;
                  st  <= ST_WB;
               end else begin
                  left <= left - 1'b1;
                  bcnt <= bcnt - 1'b1;
                  st   <= (bcnt == BURST_W'(1)) ? ST_WB : ST_XRD;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      wb_ctl = ctl;
      if (fin) begin
         wb_ctl.nm1 = '0;
         wb_ctl.cc  = CC_STOP;
      end else begin
         wb_ctl.nm1 = left;
      end
   end

   always_comb begin
      mem_re_o    = 1'b0;
      mem_we_o    = 1'b0;
      mem_addr_o  = '0;
      mem_size_o  = 2'b10;
      mem_wdata_o = '0;
      unique case (st)
         ST_DSRC: begin
            mem_re_o   = 1'b1;
            mem_addr_o = dbase;
         end
         ST_DDST: begin
            mem_re_o   = 1'b1;
            mem_addr_o = dbase + AW'(4);
         end
         ST_DCTL: begin
            mem_re_o   = 1'b1;
            mem_addr_o = dbase + AW'(8);
         end
         ST_XRD: begin
            mem_re_o   = 1'b1;
            mem_addr_o = src_addr;
            mem_size_o = ctl.src_size;
         end
         ST_XWR: begin
            mem_we_o    = 1'b1;
            mem_addr_o  = dst_addr;
            mem_size_o  = ctl.dst_size;
            mem_wdata_o = data_q;
         end
         ST_WB: begin
            mem_we_o    = 1'b1;
            mem_addr_o  = dbase + AW'(8);
            mem_wdata_o = DW'(wb_ctl);
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
   parameter int          NCH       = 8,
   parameter int          AW        = 32,
   parameter int          DW        = 32,
   parameter int unsigned DESC_BASE = 32'h200
) (
   input logic           clk,
   input logic           rst_n,
   input logic [NCH-1:0] done_o,
   input logic           mem_re_o,
   input logic           mem_we_o,
   input logic [AW-1:0]  mem_addr_o,
   input logic [1:0]     mem_size_o
);

   logic in_desc;
   logic access;

   assign in_desc = (mem_addr_o >= AW'(DESC_BASE))
                 && (mem_addr_o <  AW'(DESC_BASE + 32 * NCH));
   assign access  = mem_re_o | mem_we_o;

   // R13
   rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_re_o && mem_we_o));

   // R13
   desc_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (access && in_desc) |-> (mem_size_o == 2'b10));

   // R10
   done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(done_o));

   // R10
   done_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|done_o) |-> $past(mem_we_o && in_desc));

   // R4
   half_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (access && mem_size_o == 2'b01) |-> !mem_addr_o[0]);

   // R4
   word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (access && mem_size_o == 2'b10) |-> (mem_addr_o[1:0] == 2'b00));

endmodule

bind chan_dma_engine dma_engine_chk #(
   .NCH(NCH), .AW(AW), .DW(DW), .DESC_BASE(DESC_BASE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .done_o     (done_o),
   .mem_re_o   (mem_re_o),
   .mem_we_o   (mem_we_o),
   .mem_addr_o (mem_addr_o),
   .mem_size_o (mem_size_o)
);

// File: tb/chan_dma_engine_bench.sv
module chan_dma_engine_bench;

   localparam int CLK_P = 10;
   localparam int NCH   = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] req = '0, en = '0, hipri = '0;
   logic [NCH-1:0] done;
   logic           mre, mwe;
   logic [31:0]    maddr, mwdata, mrdata;
   logic [1:0]     msize;

   logic [7:0] mem [0:1023];
   logic [9:0] ba;

   int total = 0, bad = 0;
   int act_cnt = 0, both_cnt = 0, first_done = -1;
   int done_cnt [NCH];
   logic got_first = 1'b0;
   logic [31:0] first_addr = '0;

   always #(CLK_P/2) clk = ~clk;

   chan_dma_engine u_chan_dma_engine (
      .clk(clk), .rst_n(rst_n), .req_i(req), .ch_en_i(en), .hipri_i(hipri),
      .done_o(done), .mem_re_o(mre), .mem_we_o(mwe), .mem_addr_o(maddr),
      .mem_size_o(msize), .mem_wdata_o(mwdata), .mem_rdata_i(mrdata)
   );

   assign ba = maddr[9:0];

   always_comb begin
      case (msize)
         2'b00:   mrdata = {24'd0, mem[ba]};
         2'b01:   mrdata = {16'd0, mem[ba + 10'd1], mem[ba]};
         default: mrdata = {mem[ba + 10'd3], mem[ba + 10'd2], mem[ba + 10'd1], mem[ba]};
      endcase
   end

   always @(posedge clk) begin
      if (mwe) begin
         mem[ba] <= mwdata[7:0];
         if (msize != 2'b00) mem[ba + 10'd1] <= mwdata[15:8];
         if (msize == 2'b10) begin
            mem[ba + 10'd2] <= mwdata[23:16];
            mem[ba + 10'd3] <= mwdata[31:24];
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (mre || mwe) act_cnt++;
         if (mre && mwe) both_cnt++;
         if (mre && !got_first) begin
            got_first  = 1'b1;
            first_addr = maddr;
         end
         for (int c = 0; c < NCH; c++) begin
            if (done[c]) begin
               done_cnt[c]++;
               if (first_done < 0) first_done = c;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_ctrl(input logic [1:0] dinc, dsz, sinc, ssz,
                                           input logic [3:0] r, input logic [9:0] n1,
                                           input logic [2:0] cc);
      return {dinc, dsz, sinc, ssz, 6'd0, r, n1, 1'b0, cc};
   endfunction

   task automatic wr32(input int a, input logic [31:0] v);
      for (int i = 0; i < 4; i++) mem[a + i] = v[8*i +: 8];
   endtask

   function automatic logic [31:0] rd32(input int a);
      return {mem[a + 3], mem[a + 2], mem[a + 1], mem[a]};
   endfunction

   function automatic int daddr(input int ch, input int alt);
      return 'h200 + (alt * NCH + ch) * 16;
   endfunction

   task automatic set_desc(input int ch, input int alt, input logic [31:0] s,
                           input logic [31:0] d, input logic [31:0] ctl);
      wr32(daddr(ch, alt), s);
      wr32(daddr(ch, alt) + 4, d);
      wr32(daddr(ch, alt) + 8, ctl);
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic enable(input int ch);
      @(negedge clk);
      en[ch] = 1'b1;
      @(negedge clk);
      en[ch] = 1'b0;
   endtask

   task automatic pulse_req(input int ch);
      @(negedge clk);
      req[ch] = 1'b1;
      @(negedge clk);
      req[ch] = 1'b0;
   endtask

   task automatic wait_done(input int ch, input int cnt, input string tag);
      int n = 0;
      while (done_cnt[ch] < cnt && n < 2000) begin
         @(negedge clk);
         n++;
      end
      chk(done_cnt[ch] >= cnt, tag, done_cnt[ch], cnt);
   endtask

   task automatic clear_stats();
      act_cnt = 0; first_done = -1; got_first = 1'b0;
      for (int c = 0; c < NCH; c++) done_cnt[c] = 0;
   endtask

   task automatic t_reset();
      cycles(3);
      chk(!mre && !mwe, "R1 no access in reset", {mre, mwe}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      cycles(5);
      chk(!mre && !mwe, "R1 no access after reset", {mre, mwe}, 0);
      chk(done == '0, "R1 done low", done, 0);
   endtask

   task automatic t_basic_word();
      clear_stats();
      for (int i = 0; i < 4; i++) begin
         wr32(i * 4, 32'h1111_0000 + i);
         wr32('h100 + i * 4, 0);
      end
      set_desc(2, 0, 'h00C, 'h10C, mk_ctrl(2'b10, 2'b10, 2'b10, 2'b10, 4'd3, 10'd3, 3'b001));
      enable(2);
      @(negedge clk);
      req[2] = 1'b1;
      wait_done(2, 1, "R7 basic completes");
      req[2] = 1'b0;
      chk(first_addr == 32'h220, "R12 descriptor address", first_addr, 32'h220);
      for (int i = 0; i < 4; i++)
         chk(rd32('h100 + i * 4) == 32'h1111_0000 + i, "R3 word copy order",
             rd32('h100 + i * 4), 32'h1111_0000 + i);
      chk(rd32(daddr(2, 0) + 8) == mk_ctrl(2'b10, 2'b10, 2'b10, 2'b10, 4'd3, 10'd0, 3'b000),
          "R10 completion writeback", rd32(daddr(2, 0) + 8),
          mk_ctrl(2'b10, 2'b10, 2'b10, 2'b10, 4'd3, 10'd0, 3'b000));
      chk(done_cnt[2] == 1, "R10 single done pulse", done_cnt[2], 1);
      cycles(3);
      act_cnt = 0;
      req[2] = 1'b1;
      cycles(20);
      req[2] = 1'b0;
      chk(act_cnt == 0, "R10 finished channel ignores request", act_cnt, 0);
   endtask

   task automatic t_slot_writeback();
      clear_stats();
      for (int i = 0; i < 6; i++) begin
         wr32('h20 + i * 4, 32'h2222_0000 + i);
         wr32('h140 + i * 4, 0);
      end
      set_desc(1, 0, 'h034, 'h154, mk_ctrl(2'b10, 2'b10, 2'b10, 2'b10, 4'd1, 10'd5, 3'b001));
      enable(1);
      pulse_req(1);
      cycles(20);
      chk(rd32(daddr(1, 0) + 8) == mk_ctrl(2'b10, 2'b10, 2'b10, 2'b10, 4'd1, 10'd3, 3'b001),
          "R5 count written after 2^R", rd32(daddr(1, 0) + 8),
          mk_ctrl(2'b10, 2'b10, 2'b10, 2'b10, 4'd1, 10'd3, 3'b001));
      chk(rd32('h144) == 32'h2222_0001, "R5 second of burst", rd32('h144), 32'h2222_0001);
      chk(rd32('h148) == 0, "R7 no transfer without request", rd32('h148), 0);
      pulse_req(1);
      cycles(20);
      chk(rd32(daddr(1, 0) + 8) == mk_ctrl(2'b10, 2'b10, 2'b10, 2'b10, 4'd1, 10'd1, 3'b001),
          "R5 count after second grant", rd32(daddr(1, 0) + 8),
          mk_ctrl(2'b10, 2'b10, 2'b10, 2'b10, 4'd1, 10'd1, 3'b001));
      chk(rd32('h14C) == 32'h2222_0003, "R5 resumes at next item", rd32('h14C), 32'h2222_0003);
      chk(done_cnt[1] == 0, "R7 not yet done", done_cnt[1], 0);
   endtask

   task automatic t_auto_bytes();
      clear_stats();
      for (int i = 0; i < 5; i++) begin
         mem['h40 + i] = 8'hA0 + 8'(i);
         mem['h180 + i] = 8'h00;
      end
      mem['h185] = 8'hEE;
      set_desc(3, 0, 'h044, 'h184, mk_ctrl(2'b00, 2'b00, 2'b00, 2'b00, 4'd0, 10'd4, 3'b010));
      enable(3);
      pulse_req(3);
      wait_done(3, 1, "R8 auto completes from one request");
      for (int i = 0; i < 5; i++)
         chk(mem['h180 + i] == 8'hA0 + 8'(i), "R4 byte copy", mem['h180 + i], 8'hA0 + 8'(i));
      chk(mem['h185] == 8'hEE, "R4 no byte past end", mem['h185], 8'hEE);
   endtask

   task automatic t_steps();
      clear_stats();
      for (int i = 0; i < 3; i++) begin
         mem['h60 + 2 * i]     = 8'h10 + 8'(i);
         mem['h60 + 2 * i + 1] = 8'h50 + 8'(i);
      end
      wr32('h1A0, 32'h7777_7777);
      set_desc(4, 0, 'h064, 'h1A0, mk_ctrl(2'b11, 2'b01, 2'b01, 2'b01, 4'd3, 10'd2, 3'b001));
      enable(4);
      @(negedge clk);
      req[4] = 1'b1;
      wait_done(4, 1, "R3 fixed destination completes");
      req[4] = 1'b0;
      chk(rd32('h1A0) == 32'h7777_5212, "R3 last half lands at fixed address",
          rd32('h1A0), 32'h7777_5212);
   endtask

   task automatic t_priority(input bit hi6);
      clear_stats();
      hipri = '0;
      hipri[6] = hi6;
      for (int c = 5; c <= 6; c++) begin
         wr32('h80 + (c - 5) * 8, 32'h5 + c);
         wr32('h84 + (c - 5) * 8, 32'h9 + c);
         set_desc(c, 0, 'h84 + (c - 5) * 8, 'h1B4 + (c - 5) * 8,
                  mk_ctrl(2'b10, 2'b10, 2'b10, 2'b10, 4'd3, 10'd1, 3'b001));
      end
      @(negedge clk);
      en[5] = 1'b1; en[6] = 1'b1;
      @(negedge clk);
      en = '0;
      req[5] = 1'b1; req[6] = 1'b1;
      wait_done(5, 1, "R6 ch5 done");
      wait_done(6, 1, "R6 ch6 done");
      req = '0;
      hipri = '0;
      chk(first_done == (hi6 ? 6 : 5), "R6 grant order", first_done, hi6 ? 6 : 5);
   endtask

   task automatic t_pingpong();
      clear_stats();
      for (int i = 0; i < 5; i++) begin
         wr32('hA0 + i * 4, 32'h3333_0000 + i);
         wr32('h1C0 + i * 4, 0);
      end
      set_desc(7, 0, 'hA4, 'h1C4, mk_ctrl(2'b10, 2'b10, 2'b10, 2'b10, 4'd3, 10'd1, 3'b011));
      set_desc(7, 1, 'hB0, 'h1D0, mk_ctrl(2'b10, 2'b10, 2'b10, 2'b10, 4'd3, 10'd2, 3'b011));
      enable(7);
      @(negedge clk);
      req[7] = 1'b1;
      wait_done(7, 2, "R9 both halves complete");
      cycles(20);
      act_cnt = 0;
      cycles(20);
      req[7] = 1'b0;
      chk(act_cnt == 0, "R9 stops on invalid descriptor", act_cnt, 0);
      chk(done_cnt[7] == 2, "R9 two done pulses", done_cnt[7], 2);
      chk(rd32('h1C4) == 32'h3333_0001, "R9 primary data", rd32('h1C4), 32'h3333_0001);
      chk(rd32('h1D0) == 32'h3333_0004, "R9 alternate data", rd32('h1D0), 32'h3333_0004);
      chk(rd32(daddr(7, 1) + 8) == mk_ctrl(2'b10, 2'b10, 2'b10, 2'b10, 4'd3, 10'd0, 3'b000),
          "R10 alternate marked invalid", rd32(daddr(7, 1) + 8),
          mk_ctrl(2'b10, 2'b10, 2'b10, 2'b10, 4'd3, 10'd0, 3'b000));
   endtask

   task automatic t_enable_primary();
      clear_stats();
      set_desc(7, 0, 'hA0, 'h1E0, mk_ctrl(2'b10, 2'b10, 2'b10, 2'b10, 4'd3, 10'd0, 3'b011));
      set_desc(7, 1, 'hA0, 'h1E4, 32'h0);
      enable(7);
      @(negedge clk);
      req[7] = 1'b1;
      wait_done(7, 1, "R11 ping-pong primary done");
      cycles(20);
      req[7] = 1'b0;
      set_desc(7, 0, 'hA0, 'h1E8, mk_ctrl(2'b10, 2'b10, 2'b10, 2'b10, 4'd3, 10'd0, 3'b001));
      enable(7);
      cycles(2);
      got_first = 1'b0;
      req[7] = 1'b1;
      wait_done(7, 2, "R11 re-enabled channel runs");
      req[7] = 1'b0;
      chk(first_addr == daddr(7, 0), "R11 enable selects primary", first_addr, daddr(7, 0));
   endtask

   task automatic t_invalid(input logic [2:0] cc);
      clear_stats();
      wr32('h1F0, 32'h4444_4444);
      set_desc(0, 0, 'hA4, 'h1F4, mk_ctrl(2'b10, 2'b10, 2'b10, 2'b10, 4'd3, 10'd1, cc));
      enable(0);
      @(negedge clk);
      req[0] = 1'b1;
      cycles(15);
      act_cnt = 0;
      cycles(15);
      req[0] = 1'b0;
      chk(act_cnt == 0, "R2 invalid code disables channel", act_cnt, 0);
      chk(rd32('h1F0) == 32'h4444_4444, "R2 no data moved", rd32('h1F0), 32'h4444_4444);
      chk(done_cnt[0] == 0, "R2 no done pulse", done_cnt[0], 0);
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
      for (int c = 0; c < NCH; c++) done_cnt[c] = 0;
      t_reset();
      t_basic_word();
      t_slot_writeback();
      t_auto_bytes();
      t_steps();
      t_priority(1'b0);
      t_priority(1'b1);
      t_pingpong();
      t_enable_primary();
      t_invalid(3'b000);
      t_invalid(3'b101);
      chk(both_cnt == 0, "R13 read and write never together", both_cnt, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog all act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule